// File: doc/BRIEF.md
# Display Control Instruction Sequencer

This block runs the per-plane display control program held in video memory during blanking. At the start of vertical retrace it executes a field table. The field table starts at a fixed offset, and that offset depends on interlace parity. After every active video line, a pulse on the line input runs one line of the line table. Instructions are 32-bit words. The opcode sits in bits 31:24 and a 24-bit operand sits in bits 23:0. They are read through a synchronous port that returns data one cycle after a request.

Two address registers are kept. The video start register fetches field-table instructions and, once the field table has ended, supplies the pixel start address for the active display. The line pointer register addresses the next line of the line table. The stop, reload and signal opcodes are decoded internally. The signal opcode raises an interrupt pulse. Every other opcode, including the cursor-load opcodes 0xCD, 0xCE and 0xCF, is passed out as a register-load strobe with its opcode and operand.

Top module: `disp_ctl_seq`

## Requirements
- R1: A vsync_i pulse, even while a table is running, restarts field execution. vsr_o is set to 0x404 when interlace_i and field_even_i are both 1, and to 0x400 otherwise. The first field fetch then reads that address.
- R2: In the field table, each instruction is read from vsr_o. After each instruction that does not load the register, vsr_o advances by 4. Read data is taken one cycle after mem_req_o.
- R3: Opcode 0x00 ends the current table with no strobe and no register change, and busy_o falls.
- R4: Opcode 0x20 loads lptr_o with the operand and execution continues. Opcode 0x30 loads it and ends the table.
- R5: Opcode 0x40 loads vsr_o with the operand and continues, so the next field fetch comes from the operand. Opcode 0x50 loads vsr_o with the operand and ends the table.
- R6: Each execution of opcode 0x60 gives exactly one one-cycle irq_o pulse, including several in one field.
- R7: An hsync_i pulse while idle runs one line. The line's instructions are fetched at the line pointer and then at 4-byte steps, and at most 8 are executed.
- R8: At each line start, lptr_o advances by 32 whether or not the line ends early. A 0x20 or 0x30 inside the line then replaces that value.
- R9: Any opcode other than 0x00, 0x20, 0x30, 0x40, 0x50 and 0x60 gives a one-cycle wr_valid_o carrying the opcode on wr_op_o and the operand on wr_arg_o.
- R10: An hsync_i pulse while a table is running is ignored.
- R11: After reset, vsr_o and lptr_o are 0, busy_o is 0, and irq_o and wr_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical retrace start pulse |
| hsync_i | input | 1 | End of active line pulse |
| interlace_i | input | 1 | Interlaced scan enabled |
| field_even_i | input | 1 | Current field is the even field |
| mem_req_o | output | 1 | Instruction read request |
| mem_addr_o | output | 24 | Byte address of the instruction |
| mem_rdata_i | input | 32 | Instruction word, valid one cycle after the request |
| busy_o | output | 1 | A table is being executed |
| vsr_o | output | 24 | Video start register |
| lptr_o | output | 24 | Line-table pointer register |
| irq_o | output | 1 | Video interrupt pulse |
| wr_valid_o | output | 1 | Register-load strobe |
| wr_op_o | output | 8 | Opcode of the register load |
| wr_arg_o | output | 24 | Operand of the register load |

## Verification
Assertions check several rules on every cycle:
- the field start offset that follows a vsync pulse;
- the 32-byte line pointer step at each line start;
- a stop opcode or the eighth line instruction returning the block to idle;
- an hsync pulse during a busy run leaving the mode unchanged;
- the interrupt and the write strobe never firing together.

Only the directed scenarios can show the rest:
- the actual order of fetch addresses, including a field redirected by 0x40;
- the operands carried on the strobes;
- the interrupt count when 0x60 appears twice in one field;
- that a restarted field runs its whole table again.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned OPW  = 8;
  localparam int unsigned ARGW = 24;

  localparam logic [OPW-1:0] OPC_HALT      = 8'h00;
  localparam logic [OPW-1:0] OPC_LPTR      = 8'h20;
  localparam logic [OPW-1:0] OPC_LPTR_HALT = 8'h30;
  localparam logic [OPW-1:0] OPC_VSR       = 8'h40;
  localparam logic [OPW-1:0] OPC_VSR_HALT  = 8'h50;
  localparam logic [OPW-1:0] OPC_SIG       = 8'h60;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [ARGW-1:0] arg;
  } instr_t;

  typedef struct packed {
    logic halt;
    logic ld_lptr;
    logic ld_vsr;
    logic sig;
    logic wr;
  } dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} st_e;
endpackage

// File: rtl/dcs_decode.sv
module dcs_decode
  import dcs_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output dec_t           dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (op_i)
      OPC_HALT:      dec_o.halt = 1'b1;
      OPC_LPTR:      dec_o.ld_lptr = 1'b1;
      OPC_LPTR_HALT: begin dec_o.ld_lptr = 1'b1; dec_o.halt = 1'b1; end
      OPC_VSR:       dec_o.ld_vsr = 1'b1;
      OPC_VSR_HALT:  begin dec_o.ld_vsr = 1'b1; dec_o.halt = 1'b1; end
      OPC_SIG:       dec_o.sig = 1'b1;
      default:       dec_o.wr = 1'b1;
    endcase
  end
endmodule

// File: rtl/dcs_regs.sv
module dcs_regs
  import dcs_pkg::*;
#(
  parameter logic [ARGW-1:0] FIELD_BASE = 24'h000400,
  parameter int unsigned     LINE_LEN   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_field_i,
  input  logic            alt_start_i,
  input  logic            start_line_i,
  input  logic            exec_i,
  input  logic            exec_field_i,
  input  logic            ld_vsr_i,
  input  logic            ld_lptr_i,
  input  logic [ARGW-1:0] arg_i,
  output logic [ARGW-1:0] vsr_o,
  output logic [ARGW-1:0] lptr_o
);
  localparam logic [ARGW-1:0] STEP       = ARGW'(4);
  localparam logic [ARGW-1:0] LINE_BYTES = ARGW'(LINE_LEN * 4);
  localparam logic [ARGW-1:0] ALT_START  = FIELD_BASE + STEP;

  logic [ARGW-1:0] vsr_q, lptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsr_q <= '0;
    end else if (start_field_i) begin
      vsr_q <= alt_start_i ? ALT_START : FIELD_BASE;
    end else if (exec_i && ld_vsr_i) begin
      vsr_q <= arg_i;
    end else if (exec_field_i) begin
      vsr_q <= vsr_q + STEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lptr_q <= '0;
    end else if (start_line_i) begin
      lptr_q <= lptr_q + LINE_BYTES;
    end else if (exec_i && ld_lptr_i) begin
      lptr_q <= arg_i;
    end
  end

  assign vsr_o  = vsr_q;
  assign lptr_o = lptr_q;

  AST_FIELD_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_field_i |=> vsr_q == ($past(alt_start_i) ? ALT_START : FIELD_BASE)); // R1
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_line_i |=> lptr_q == $past(lptr_q) + LINE_BYTES); // R8
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
  import dcs_pkg::*;
#(
  parameter int unsigned LINE_LEN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vsync_i,
  input  logic            hsync_i,
  input  logic [ARGW-1:0] vsr_i,
  input  logic [ARGW-1:0] lptr_i,
  input  instr_t          instr_i,
  input  logic            halt_i,
  input  logic            sig_i,
  input  logic            wr_i,
  output logic            start_line_o,
  output logic            exec_o,
  output logic            exec_field_o,
  output logic            mem_req_o,
  output logic [ARGW-1:0] mem_addr_o,
  output logic            busy_o,
  output logic            irq_o,
  output logic            wr_valid_o,
  output logic [OPW-1:0]  wr_op_o,
  output logic [ARGW-1:0] wr_arg_o
);
  localparam int unsigned     CW   = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam logic [CW-1:0]   LAST = CW'(LINE_LEN - 1);
  localparam logic [ARGW-1:0] STEP = ARGW'(4);

  st_e             state_q;
  logic            field_q;
  logic [ARGW-1:0] laddr_q;
  logic [CW-1:0]   cnt_q;
  logic            last_line, done;
  logic            irq_q, wr_q;
  logic [OPW-1:0]  wop_q;
  logic [ARGW-1:0] warg_q;

  assign start_line_o = hsync_i && !vsync_i && (state_q == ST_IDLE);
  assign exec_o       = (state_q == ST_EXEC) && !vsync_i;
  assign exec_field_o = exec_o && field_q;
  assign last_line    = !field_q && (cnt_q == LAST);
  assign done         = halt_i || last_line;
  assign mem_req_o    = (state_q == ST_FETCH);
  assign mem_addr_o   = field_q ? vsr_i : laddr_q;
  assign busy_o       = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      field_q <= 1'b0;
      laddr_q <= '0;
      cnt_q   <= '0;
    end else if (vsync_i) begin
      state_q <= ST_FETCH;
      field_q <= 1'b1;
    end else if (start_line_o) begin
      state_q <= ST_FETCH;
      field_q <= 1'b0;
      laddr_q <= lptr_i;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: state_q <= ST_EXEC;
        ST_EXEC: begin
          state_q <= done ? ST_IDLE : ST_FETCH;
          if (!field_q) begin
            laddr_q <= laddr_q + STEP;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // strobes registered one cycle after execution
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wr_q   <= 1'b0;
      wop_q  <= '0;
      warg_q <= '0;
    end else begin
      irq_q <= exec_o && sig_i;
      wr_q  <= exec_o && wr_i;
      if (exec_o && wr_i) begin
        wop_q  <= instr_i.op;
        warg_q <= instr_i.arg;
      end
    end
  end

  assign irq_o      = irq_q;
  assign wr_valid_o = wr_q;
  assign wr_op_o    = wop_q;
  assign wr_arg_o   = warg_q;

  AST_HALT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && halt_i) |=> state_q == ST_IDLE); // R3
  AST_LINE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && !field_q && cnt_q == LAST) |=> state_q == ST_IDLE); // R7
  AST_HSYNC_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i && !vsync_i && state_q != ST_IDLE) |=> field_q == $past(field_q)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_q && wr_q)); // R9
endmodule

// File: rtl/disp_ctl_seq.sv
module disp_ctl_seq
  import dcs_pkg::*;
#(
  parameter logic [23:0] FIELD_BASE = 24'h000400,
  parameter int unsigned LINE_LEN   = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        vsync_i,
  input  logic        hsync_i,
  input  logic        interlace_i,
  input  logic        field_even_i,
  output logic        mem_req_o,
  output logic [23:0] mem_addr_o,
  input  logic [31:0] mem_rdata_i,
  output logic        busy_o,
  output logic [23:0] vsr_o,
  output logic [23:0] lptr_o,
  output logic        irq_o,
  output logic        wr_valid_o,
  output logic [7:0]  wr_op_o,
  output logic [23:0] wr_arg_o
);
  instr_t          instr;
  dec_t            dec;
  logic            start_line, exec, exec_field;
  logic [ARGW-1:0] vsr, lptr;

  assign instr = instr_t'(mem_rdata_i);

  dcs_decode u_dec (
    .op_i  (instr.op),
    .dec_o (dec)
  );

  dcs_regs #(.FIELD_BASE(FIELD_BASE), .LINE_LEN(LINE_LEN)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_field_i (vsync_i),
    .alt_start_i   (interlace_i && field_even_i),
    .start_line_i  (start_line),
    .exec_i        (exec),
    .exec_field_i  (exec_field),
    .ld_vsr_i      (dec.ld_vsr),
    .ld_lptr_i     (dec.ld_lptr),
    .arg_i         (instr.arg),
    .vsr_o         (vsr),
    .lptr_o        (lptr)
  );

  dcs_seq #(.LINE_LEN(LINE_LEN)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vsync_i      (vsync_i),
    .hsync_i      (hsync_i),
    .vsr_i        (vsr),
    .lptr_i       (lptr),
    .instr_i      (instr),
    .halt_i       (dec.halt),
    .sig_i        (dec.sig),
    .wr_i         (dec.wr),
    .start_line_o (start_line),
    .exec_o       (exec),
    .exec_field_o (exec_field),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .busy_o       (busy_o),
    .irq_o        (irq_o),
    .wr_valid_o   (wr_valid_o),
    .wr_op_o      (wr_op_o),
    .wr_arg_o     (wr_arg_o)
  );

  assign vsr_o  = vsr;
  assign lptr_o = lptr;
endmodule

// File: tb/disp_ctl_seq_tb_top.sv
module disp_ctl_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vsync = 1'b0, hsync = 1'b0, ilace = 1'b0, even = 1'b0;
  logic        mem_req, busy, irq, wr_valid;
  logic [23:0] mem_addr, vsr, lptr, wr_arg;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  wr_op;

  logic [31:0] mem [0:1023];
  int nchk = 0, nerr = 0;
  int irq_cnt = 0, wr_n = 0, fa_n = 0;
  logic [31:0] wr_log [0:63];
  logic [23:0] fa_log [0:63];

  always #2 clk = ~clk;

  disp_ctl_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .vsync_i(vsync), .hsync_i(hsync),
    .interlace_i(ilace), .field_even_i(even), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .busy_o(busy),
    .vsr_o(vsr), .lptr_o(lptr), .irq_o(irq), .wr_valid_o(wr_valid),
    .wr_op_o(wr_op), .wr_arg_o(wr_arg)
  );

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[11:2]];

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (wr_valid && wr_n < 64) begin wr_log[wr_n] = {wr_op, wr_arg}; wr_n++; end
    if (mem_req && fa_n < 64) begin fa_log[fa_n] = mem_addr; fa_n++; end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(int a, logic [7:0] op, logic [23:0] arg);
    mem[a >> 2] = {op, arg};
  endtask

  task automatic clr();
    irq_cnt = 0; wr_n = 0; fa_n = 0;
  endtask

  task automatic pulse_v();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
  endtask

  task automatic pulse_h();
    @(negedge clk) hsync = 1'b1;
    @(negedge clk) hsync = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 vsr", {8'h0, vsr}, 32'h0);
    chk("R11 lptr", {8'h0, lptr}, 32'h0);
    chk("R11 busy/irq/wr", {29'h0, busy, irq, wr_valid}, 32'h0);
  endtask

  task automatic t_field_basic();
    clr(); ilace = 1'b0;
    pulse_v(); wait_idle();
    chk("R2 fetch count", fa_n, 7);
    chk("R1 first fetch", {8'h0, fa_log[0]}, 32'h400);
    chk("R2 step fetch", {8'h0, fa_log[3]}, 32'h40C);
    chk("R5 redirect fetch", {8'h0, fa_log[4]}, 32'h500);
    chk("R5 vsr after 0x50", {8'h0, vsr}, 32'hA00);
    chk("R4 lptr after 0x20", {8'h0, lptr}, 32'h800);
    chk("R6 irq count", irq_cnt, 2);
    chk("R9 strobe count", wr_n, 2);
    chk("R9 strobe 0", wr_log[0], 32'hCD000111);
    chk("R9 strobe 1", wr_log[1], 32'hCE000222);
  endtask

  task automatic t_line_full();
    clr();
    for (int k = 0; k < 9; k++) put(32'h800 + 4*k, 8'hCF, 24'(k));
    pulse_h(); wait_idle();
    chk("R7 line cap", fa_n, 8);
    chk("R7 first line fetch", {8'h0, fa_log[0]}, 32'h800);
    chk("R7 last line fetch", {8'h0, fa_log[7]}, 32'h81C);
    chk("R9 line strobes", wr_n, 8);
    chk("R9 line strobe 7", wr_log[7], 32'hCF000007);
    chk("R8 lptr step", {8'h0, lptr}, 32'h820);
  endtask

  task automatic t_line_stop();
    clr();
    put(32'h820, 8'hCD, 24'h5);
    put(32'h824, 8'h00, 24'h123456);
    pulse_h(); wait_idle();
    chk("R3 early stop fetches", fa_n, 2);
    chk("R3 stop no strobe", wr_n, 1);
    chk("R8 lptr after early stop", {8'h0, lptr}, 32'h840);
    chk("R3 vsr unchanged", {8'h0, vsr}, 32'hA00);
  endtask

  task automatic t_line_reload();
    clr();
    put(32'h840, 8'h20, 24'h900);
    put(32'h844, 8'h40, 24'hC00);
    put(32'h848, 8'h30, 24'h980);
    pulse_h(); wait_idle();
    chk("R4 0x30 stops", fa_n, 3);
    chk("R4 lptr reload", {8'h0, lptr}, 32'h980);
    chk("R5 vsr reload in line", {8'h0, vsr}, 32'hC00);
  endtask

  task automatic t_interlace();
    clr(); ilace = 1'b1; even = 1'b1;
    pulse_v(); wait_idle();
    chk("R1 even start", {8'h0, fa_log[0]}, 32'h404);
    chk("R1 even fetches", fa_n, 6);
    chk("R6 irq even", irq_cnt, 2);
    clr(); even = 1'b0;
    pulse_v(); wait_idle();
    chk("R1 odd start", {8'h0, fa_log[0]}, 32'h400);
    ilace = 1'b0;
  endtask

  task automatic t_hsync_busy();
    clr();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) begin vsync = 1'b0; hsync = 1'b1; end
    @(negedge clk) hsync = 1'b0;
    wait_idle();
    chk("R10 fetches", fa_n, 7);
    chk("R10 lptr", {8'h0, lptr}, 32'h800);
  endtask

  task automatic t_vsync_restart();
    clr();
    pulse_v();
    repeat (3) @(negedge clk);
    pulse_v(); wait_idle();
    chk("R1 restart longer run", {31'h0, fa_n > 7}, 32'h1);
    chk("R1 restart from base", {8'h0, fa_log[fa_n - 7]}, 32'h400);
    chk("R1 restart completes", {8'h0, vsr}, 32'hA00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    put(32'h400, 8'hCD, 24'h000111);
    put(32'h404, 8'h60, 24'h0);
    put(32'h408, 8'h20, 24'h000800);
    put(32'h40C, 8'h40, 24'h000500);
    put(32'h500, 8'hCE, 24'h000222);
    put(32'h504, 8'h60, 24'h0);
    put(32'h508, 8'h50, 24'h000A00);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_field_basic();
    t_line_full();
    t_line_stop();
    t_line_reload();
    t_interlace();
    t_hsync_busy();
    t_vsync_restart();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule